// File: doc/BRIEF.md
# Column-Parallel 2x2 Cluster Threshold Detector

This block looks at a row of detector column channels, each of which supplies one Gray-coded 5-bit sample on every clock. Each clock is one time step. Every channel converts its code to binary and keeps the sample from the step before. It adds the two together, which gives a two-step partial sum for that channel. It then adds the partial sum handed over by its right-hand neighbour. The result covers a window of two channels by two time steps. A particle whose charge spreads over adjacent pixels therefore still produces a large enough total to be noticed.

Each channel compares its window total against its own programmable threshold and raises a hit flag when the total is strictly greater. The binary pixel values are also passed on, so that the storage downstream can capture them together with the hit decisions. Thresholds start at the largest representable value, so the detector stays silent until software lowers them through a simple write port.

Top module: `cluster_finder`

## Requirements
- R1: Every clock edge outside reset takes one new time step from `code_in`. The binary value of each channel appears on `pix_out` one clock after its code was sampled.
- R2: The input code is reflected binary (Gray). Binary bit 4 equals code bit 4, and binary bit k equals the XOR of code bits 4 down to k.
- R3: `hit_out[i]` is registered. It is set one clock after `pix_out` shows step t if and only if the window total is strictly greater than the threshold of channel i. The window total is the binary values of channels i and i+1 at steps t and t-1 added together. The total is formed in 7 bits, so the maximum 124 never wraps.
- R4: Reset sets every threshold to 127. No input pattern raises a hit until a threshold has been lowered.
- R5: When `thr_we` is high on a clock edge and `thr_addr` is below the channel count, the threshold of that channel takes `thr_data`. A write to an address at or above the channel count changes no threshold.
- R6: The highest-numbered channel has no right-hand neighbour. Its window total is its own two-step sum plus zero.
- R7: A clock edge with `rst_n` low clears `pix_out`, `hit_out` and every channel's stored previous sample. The first step after reset therefore sums with a previous value of 0.
- R8: Each channel compares only against its own threshold. Writing one channel's threshold leaves the decisions of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one edge per time step |
| rst_n | input | 1 | Synchronous reset, active low |
| code_in | input | N_CH*5 | Gray-coded samples; channel i occupies bits [5i+4:5i] |
| thr_we | input | 1 | Threshold write enable |
| thr_addr | input | ADDR_W | Channel index of the threshold write |
| thr_data | input | 7 | Threshold value to store |
| pix_out | output | N_CH*5 | Binary samples, one clock after input, same packing as `code_in` |
| hit_out | output | N_CH | Hit flag of the window starting at each channel |

## Verification
The bench builds the detector with six channels. With six channels the 3-bit address field has two codes, 6 and 7, that point at no channel, so the rule that such writes are ignored can be tested. Six channels is also small enough to follow the boundary channel 5, with its missing neighbour, next to ordinary interior channels. The 5-bit sample width is kept, so all-ones inputs reach the full total of 124. Thresholds of 123, 124 and 127 then probe the strict comparison and show that the adders do not wrap.

// File: rtl/cluster_pkg.sv
// Shared widths and types for the cluster threshold detector.
// Assumes samples are 5 bits wide; all derived widths follow from CODE_W.
package cluster_pkg;
    localparam int CODE_W  = 5;
    localparam int PSUM_W  = CODE_W + 1;     // two samples of one channel
    localparam int KSUM_W  = CODE_W + 2;     // four samples of a 2x2 window
    localparam logic [KSUM_W-1:0] THR_MAX = '1;

    typedef logic [CODE_W-1:0] pix_t;
    typedef logic [PSUM_W-1:0] psum_t;
    typedef logic [KSUM_W-1:0] ksum_t;
endpackage

// File: rtl/gray_to_bin.sv
// Combinational reflected-binary to binary converter.
// Assumes nothing about timing; purely a function of the input code.
module gray_to_bin
    import cluster_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output pix_t              bin
);
    // Each binary bit is the parity of the code bits at and above it.
    for (genvar k = 0; k < CODE_W; k++) begin : g_bit
        assign bin[k] = ^code[CODE_W-1:k];
    end
endmodule

// File: rtl/thresh_bank.sv
// Per-channel threshold registers with a single write port.
// Assumes at most one write per clock; addresses >= N_CH are dropped.
module thresh_bank
    import cluster_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  ksum_t             data,
    output ksum_t             thr [N_CH]
);
    for (genvar i = 0; i < N_CH; i++) begin : g_thr
        // Load this channel's threshold on an addressed write; reset to max.
        always_ff @(posedge clk) begin
            if (!rst_n)
                thr[i] <= THR_MAX;
            else if (we && (int'(addr) == i))
                thr[i] <= data;
        end
    end
endmodule

// File: rtl/kernel_lane.sv
// One channel of the 2x2 window detector: converts the code, keeps the
// previous step, forms the channel partial sum, adds the neighbour's and
// compares against the local threshold. Assumes one step per clock.
module kernel_lane
    import cluster_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    input  psum_t             nb_psum,
    input  ksum_t             thr,
    output psum_t             psum,
    output pix_t              pix,
    output logic              hit
);
    pix_t  bin_w;
    pix_t  cur_q;
    pix_t  prev_q;
    ksum_t ksum;

    gray_to_bin u_conv (
        .code (code),
        .bin  (bin_w)
    );

    // Capture the current step and shift the old one into the delay stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            cur_q  <= bin_w;
            prev_q <= cur_q;
        end
    end

    // Two-step partial sum of this channel and the full window total.
    always_comb begin
        psum = PSUM_W'(cur_q) + PSUM_W'(prev_q);
        ksum = KSUM_W'(psum)  + KSUM_W'(nb_psum);
    end

    // Register the strict threshold decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hit <= 1'b0;
        else
            hit <= (ksum > thr);
    end

    assign pix = cur_q;
endmodule

// File: rtl/cluster_finder.sv
// Top of the column-parallel 2x2 cluster threshold detector.
// Chains N_CH lanes so that lane i receives the partial sum of lane i+1;
// the last lane receives zero. Assumes one time step per clock.
module cluster_finder
    import cluster_pkg::*;
#(
    parameter  int N_CH   = 8,
    localparam int ADDR_W = (N_CH > 1) ? $clog2(N_CH) : 1
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CH*CODE_W-1:0] code_in,
    input  logic                   thr_we,
    input  logic [ADDR_W-1:0]      thr_addr,
    input  logic [KSUM_W-1:0]      thr_data,
    output logic [N_CH*CODE_W-1:0] pix_out,
    output logic [N_CH-1:0]        hit_out
);
    ksum_t thr_w  [N_CH];
    psum_t psum_w [N_CH];
    psum_t nb_w   [N_CH];

    thresh_bank #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (thr_we),
        .addr  (thr_addr),
        .data  (thr_data),
        .thr   (thr_w)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_lane
        // Right-hand neighbour's partial sum, or zero at the array edge.
        if (i == N_CH - 1) begin : g_edge
            assign nb_w[i] = '0;
        end else begin : g_mid
            assign nb_w[i] = psum_w[i+1];
        end

        kernel_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .code    (code_in[i*CODE_W +: CODE_W]),
            .nb_psum (nb_w[i]),
            .thr     (thr_w[i]),
            .psum    (psum_w[i]),
            .pix     (pix_out[i*CODE_W +: CODE_W]),
            .hit     (hit_out[i])
        );
    end
endmodule

// File: rtl/cluster_finder_chk.sv
// Assertion checker for cluster_finder, bound to every instance.
// Observes ports plus the threshold bank outputs.
module cluster_finder_chk
    import cluster_pkg::*;
#(
    parameter int N_CH   = 8,
    parameter int ADDR_W = 3
)(
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_CH*CODE_W-1:0] code_in,
    input logic                   thr_we,
    input logic [ADDR_W-1:0]      thr_addr,
    input logic [KSUM_W-1:0]      thr_data,
    input logic [N_CH*CODE_W-1:0] pix_out,
    input logic [N_CH-1:0]        hit_out,
    input ksum_t                  thr    [N_CH]
);
    function automatic pix_t to_bin(input logic [CODE_W-1:0] g);
        pix_t b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int k = CODE_W - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
        return b;
    endfunction

    logic [N_CH*CODE_W-1:0] prev_pix;
    // Remember the previously shown pixel row; history is zero after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_pix <= '0;
        else        prev_pix <= pix_out;
    end

    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> (hit_out == '0 && pix_out == '0));

    for (genvar i = 0; i < N_CH; i++) begin : g_chk
        ksum_t own_s;
        ksum_t nb_s;
        assign own_s = KSUM_W'(pix_out[i*CODE_W +: CODE_W])
                     + KSUM_W'(prev_pix[i*CODE_W +: CODE_W]);
        if (i == N_CH - 1) begin : g_last
            assign nb_s = '0;
            p_hit_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (hit_out[i] == $past(own_s > thr[i])));
        end else begin : g_inner
            assign nb_s = KSUM_W'(pix_out[(i+1)*CODE_W +: CODE_W])
                        + KSUM_W'(prev_pix[(i+1)*CODE_W +: CODE_W]);
            p_hit_kernel_r3: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> (hit_out[i] == $past((own_s + nb_s) > thr[i])));
        end

        p_pix_convert_r2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (pix_out[i*CODE_W +: CODE_W]
                      == $past(to_bin(code_in[i*CODE_W +: CODE_W]))));

        p_thr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_we && int'(thr_addr) == i) |=> (thr[i] == $past(thr_data)));

        p_thr_reset_r4: assert property (@(posedge clk)
            !rst_n |=> (thr[i] == THR_MAX));

        p_thr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !(thr_we && int'(thr_addr) == i) |=> $stable(thr[i]));
    end
endmodule

bind cluster_finder cluster_finder_chk #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .code_in  (code_in),
    .thr_we   (thr_we),
    .thr_addr (thr_addr),
    .thr_data (thr_data),
    .pix_out  (pix_out),
    .hit_out  (hit_out),
    .thr      (thr_w)
);

// File: tb/cluster_finder_test.sv
// Directed bench for cluster_finder with six channels.
module cluster_finder_test;
    localparam int N  = 6;
    localparam int CW = 5;
    localparam int AW = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*CW-1:0] code_in = '0;
    logic            thr_we = 1'b0;
    logic [AW-1:0]   thr_addr = '0;
    logic [6:0]      thr_data = '0;
    logic [N*CW-1:0] pix_out;
    logic [N-1:0]    hit_out;

    int checks = 0;
    int errors = 0;

    // Bench model: intended binary inputs, current/previous step, thresholds.
    int       cur_v [N];
    int       mb    [N];
    int       mp    [N];
    int       mthr  [N];
    logic [N-1:0] mhit;

    always #5 clk = ~clk;

    cluster_finder #(.N_CH(N)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_in  (code_in),
        .thr_we   (thr_we),
        .thr_addr (thr_addr),
        .thr_data (thr_data),
        .pix_out  (pix_out),
        .hit_out  (hit_out)
    );

    task automatic put(input int a, input int b, input int c,
                       input int d, input int e, input int f);
        cur_v[0] = a; cur_v[1] = b; cur_v[2] = c;
        cur_v[3] = d; cur_v[4] = e; cur_v[5] = f;
        for (int i = 0; i < N; i++)
            code_in[i*CW +: CW] = CW'(cur_v[i] ^ (cur_v[i] >> 1));
    endtask

    // One clock edge, update the model, then compare at the falling edge.
    task automatic step(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                mb[i] = 0; mp[i] = 0; mthr[i] = 127;
            end
            mhit = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                int s;
                s = mb[i] + mp[i];
                if (i < N - 1) s = s + mb[i+1] + mp[i+1];
                mhit[i] = (s > mthr[i]);
            end
            if (thr_we && int'(thr_addr) < N) mthr[thr_addr] = int'(thr_data);
            for (int i = 0; i < N; i++) begin
                mp[i] = mb[i];
                mb[i] = cur_v[i];
            end
        end
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            checks++;
            if (int'(pix_out[i*CW +: CW]) != mb[i]) begin
                errors++;
                $display("FAIL %s pix ch%0d: got %0d expected %0d",
                         tag, i, pix_out[i*CW +: CW], mb[i]);
            end
        end
        checks++;
        if (hit_out !== mhit) begin
            errors++;
            $display("FAIL %s hit_out: got %b expected %b", tag, hit_out, mhit);
        end
    endtask

    task automatic wr_thr(input int ch, input int val, input string tag);
        thr_we = 1'b1; thr_addr = AW'(ch); thr_data = 7'(val);
        step(tag);
        thr_we = 1'b0;
    endtask

    task automatic t_reset;
        put(0, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        step("R7 reset");
        step("R7 reset");
        rst_n = 1'b1;
        step("R7 idle");
    endtask

    task automatic t_unconfigured;
        put(31, 31, 31, 31, 31, 31);
        step("R4"); step("R4"); step("R4");
        put(0, 0, 0, 0, 0, 0);
        step("R4"); step("R4");
    endtask

    task automatic t_gray;
        put(1, 2, 3, 4, 5, 6);       step("R2 R1");
        put(0, 5, 10, 21, 30, 31);   step("R2 R1");
        put(16, 8, 4, 2, 1, 0);      step("R2 R1");
        put(7, 15, 23, 27, 29, 30);  step("R2 R1");
        put(0, 0, 0, 0, 0, 0);       step("R2"); step("R2");
    endtask

    task automatic t_write;
        wr_thr(2, 20, "R5 write");
        wr_thr(6, 0, "R5 out of range");
        wr_thr(7, 0, "R5 out of range");
        put(0, 0, 0, 0, 31, 31);     step("R5"); step("R5");
        put(0, 0, 9, 9, 0, 0);       step("R5"); step("R5");
        put(0, 0, 0, 0, 0, 0);       step("R5"); step("R5");
    endtask

    task automatic t_boundary;
        put(0, 0, 5, 5, 0, 0);       step("R3 equal");
        step("R3 equal");
        put(0, 0, 6, 5, 0, 0);       step("R3 above");
        put(0, 0, 0, 0, 0, 0);       step("R3 above"); step("R3"); step("R3");
        wr_thr(0, 123, "R3 max");
        wr_thr(1, 124, "R3 max");
        put(31, 31, 31, 31, 31, 31); step("R3 max"); step("R3 max"); step("R3 max");
        put(0, 0, 0, 0, 0, 0);       step("R3"); step("R3"); step("R3");
    endtask

    task automatic t_edge;
        wr_thr(5, 5, "R6 write");
        put(0, 0, 0, 0, 0, 3);       step("R6"); step("R6");
        put(0, 0, 0, 0, 0, 0);       step("R6"); step("R6");
        put(0, 0, 0, 0, 0, 2);       step("R6 low");
        put(0, 0, 0, 0, 0, 3);       step("R6 low");
        put(0, 0, 0, 0, 0, 0);       step("R6"); step("R6");
    endtask

    task automatic t_indep;
        wr_thr(3, 0, "R8 write");
        put(0, 0, 0, 0, 1, 0);       step("R8"); step("R8");
        put(1, 0, 0, 0, 0, 0);       step("R8"); step("R8");
        put(0, 0, 0, 0, 0, 0);       step("R8"); step("R8"); step("R8");
    endtask

    task automatic t_history;
        put(31, 31, 0, 0, 0, 0);     step("R7 fill"); step("R7 fill");
        rst_n = 1'b0;                step("R7 mid reset");
        rst_n = 1'b1;
        put(1, 0, 0, 0, 0, 0);
        wr_thr(0, 1, "R7 first step");
        put(0, 0, 0, 0, 0, 0);       step("R7 prev cleared");
        put(31, 31, 31, 31, 31, 31); step("R4 after reset"); step("R4 after reset");
        put(0, 0, 0, 0, 0, 0);       step("R4"); step("R4");
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            cur_v[i] = 0; mb[i] = 0; mp[i] = 0; mthr[i] = 127;
        end
        mhit = '0;
        t_reset();
        t_unconfigured();
        t_gray();
        t_write();
        t_boundary();
        t_edge();
        t_indep();
        t_history();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule